// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, A and B, lane for lane. Each direction has its own enable, its own source select and its own storage register. The A-to-B direction drives the B side with either the live level of the A bus or the contents of its register. The B-to-A direction does the same for the A side. Each register loads the level of its source bus on a rising edge of a dedicated capture strobe. It does so whatever the enables and selects are set to. Each bus is presented as a triple of input, driven value and output enable, so the surrounding logic resolves the wires itself. No tri-state primitives are needed.

The capture strobes are sampled by the block clock and acted on at their rising edge, so the whole block is synchronous to `clk`. When both directions are enabled and both pass live data, the two buses feed each other. A real circuit would latch its last state in that case. This model holds that state in a register instead, which an outside driver on either bus can overwrite. A parameter selects between the true-data variant and the inverted-data variant.

Top module: `dual_path_xcvr`

## Requirements
- R1: On a `clk` edge where `strobe_ab` is 1 and was 0 at the previous edge, the A-to-B register loads the A bus level. This happens regardless of enables and selects. The A bus level is `a_in` when the A side is not driven, and the value the block drives otherwise. At all other edges the register keeps its value.
- R2: The same rule as R1 applies to `strobe_ba`. Here the B-to-A register loads the B bus level.
- R3: `b_oe` equals `en_ab` (active high) and `a_oe` equals the inverse of `en_ba_n` (active low). While an output enable is 0, its data output is all zeros.
- R4: With only the A-to-B direction enabled, `sel_ab` = 0 drives the live `a_in` onto `b_out`. `sel_ab` = 1 drives the A-to-B register onto `b_out`.
- R5: With only the B-to-A direction enabled, `sel_ba` = 0 drives the live `b_in` onto `a_out`. `sel_ba` = 1 drives the B-to-A register onto `a_out`.
- R6: With neither direction enabled, both output enables are 0 and both outputs are zero. Captures still occur and are visible later through a select of 1.
- R7: With both directions enabled and both selects 0, the block is in loop mode. `a_out` shows the hold register and `b_out` shows the hold register passed through the data transform. The hold register keeps its value while neither external-driver flag is set.
- R8: In loop mode, the hold register loads at the next edge. It takes `a_in` when `a_ext_vld` is 1. Otherwise it takes the transformed `b_in` when `b_ext_vld` is 1. Outside loop mode it loads the A bus level at every edge.
- R9: With both directions enabled and both selects 1, `a_out` shows the B-to-A register and `b_out` shows the A-to-B register at the same time.
- R10: With INVERT = 0 the transform passes data unchanged. With INVERT = 1 every bit driven onto either bus is complemented.
- R11: An active-low `rst_n` clears both storage registers and the hold register to zero.
- R12: With both directions enabled and exactly one select at 1, the stored side drives its bus. The other side drives the transform of that driven bus level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| strobe_ab | input | 1 | Capture strobe of the A-to-B register (rising edge) |
| strobe_ba | input | 1 | Capture strobe of the B-to-A register (rising edge) |
| en_ab | input | 1 | A-to-B enable, active high; drives the B side |
| en_ba_n | input | 1 | B-to-A enable, active low; drives the A side |
| sel_ab | input | 1 | A-to-B source: 0 live, 1 stored |
| sel_ba | input | 1 | B-to-A source: 0 live, 1 stored |
| a_in | input | 8 | Level seen on the A bus from outside |
| a_ext_vld | input | 1 | An outside driver is active on the A bus |
| a_out | output | 8 | Value the block drives onto the A bus |
| a_oe | output | 1 | A-side output enable |
| b_in | input | 8 | Level seen on the B bus from outside |
| b_ext_vld | input | 1 | An outside driver is active on the B bus |
| b_out | output | 8 | Value the block drives onto the B bus |
| b_oe | output | 1 | B-side output enable |

## Verification
The bench sweeps all sixteen enable and select combinations on two instances, one true and one inverted, and compares them with a two-pass bus-resolution model. One corner case is a capture strobe that rises while its register is being shown. A design that loads early or late would show the new value one cycle off. In loop mode the bench changes the inputs with no outside driver present, to catch a design that leaks live data instead of holding. It then raises each external-driver flag, to catch a wrong priority or a missing transform. Mixed modes and captures while the bus is driven by the block itself expose a design that reads `a_in` instead of the resolved bus level.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef struct packed {
    logic en_ab;
    logic en_ba;
    logic sel_ab;
    logic sel_ba;
  } xcvr_ctl_t;

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic             strobe_q;
  logic             take;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] data_d;

  always_comb begin
    take   = strobe & ~strobe_q;
    data_d = data_q;
    if (take) begin
      data_d = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      data_q   <= '0;
    end else begin
      strobe_q <= strobe;
      data_q   <= data_d;
    end
  end

  assign q = data_q;

  // R1, R2
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !strobe_q) |=> (q == $past(d)));

  // R1, R2
  cap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe && !strobe_q) |=> $stable(q));

endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
  import xcvr_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int INVERT = 0
) (
  input  xcvr_ctl_t        ctl,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [WIDTH-1:0] reg_ab,
  input  logic [WIDTH-1:0] reg_ba,
  input  logic [WIDTH-1:0] hold_val,
  output logic [WIDTH-1:0] a_lvl,
  output logic [WIDTH-1:0] b_lvl,
  output logic [WIDTH-1:0] a_drv,
  output logic [WIDTH-1:0] b_drv,
  output logic             loop_mode
);

  logic [WIDTH-1:0] flip;

  generate
    if (INVERT != 0) begin : g_inverted
      assign flip = '1;
    end else begin : g_true
      assign flip = '0;
    end
  endgenerate

  always_comb begin
    loop_mode = ctl.en_ab & ctl.en_ba & ~ctl.sel_ab & ~ctl.sel_ba;
    a_lvl     = a_in;
    b_lvl     = b_in;
    unique case ({ctl.en_ba, ctl.en_ab})
      2'b00: begin
        a_lvl = a_in;
        b_lvl = b_in;
      end
      2'b01: begin
        b_lvl = (ctl.sel_ab ? reg_ab : a_in) ^ flip;
      end
      2'b10: begin
        a_lvl = (ctl.sel_ba ? reg_ba : b_in) ^ flip;
      end
      default: begin
        if (loop_mode) begin
          a_lvl = hold_val;
          b_lvl = hold_val ^ flip;
        end else if (ctl.sel_ab && ctl.sel_ba) begin
          a_lvl = reg_ba ^ flip;
          b_lvl = reg_ab ^ flip;
        end else if (ctl.sel_ab) begin
          b_lvl = reg_ab ^ flip;
          a_lvl = b_lvl ^ flip;
        end else begin
          a_lvl = reg_ba ^ flip;
          b_lvl = a_lvl ^ flip;
        end
      end
    endcase
    a_drv = ctl.en_ba ? a_lvl : '0;
    b_drv = ctl.en_ab ? b_lvl : '0;
  end

endmodule

// File: rtl/xcvr_loop_hold.sv
module xcvr_loop_hold #(
  parameter int WIDTH  = 8,
  parameter int INVERT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loop_mode,
  input  logic             a_ext_vld,
  input  logic             b_ext_vld,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [WIDTH-1:0] a_lvl,
  output logic [WIDTH-1:0] hold_val
);

  logic [WIDTH-1:0] flip;
  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] hold_d;

  generate
    if (INVERT != 0) begin : g_inverted
      assign flip = '1;
    end else begin : g_true
      assign flip = '0;
    end
  endgenerate

  always_comb begin
    hold_d = hold_q;
    if (!loop_mode) begin
      hold_d = a_lvl;
    end else if (a_ext_vld) begin
      hold_d = a_in;
    end else if (b_ext_vld) begin
      hold_d = b_in ^ flip;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_d;
    end
  end

  assign hold_val = hold_q;

  // R7
  loop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_mode && !a_ext_vld && !b_ext_vld) |=> $stable(hold_val));

  // R8
  loop_ext_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_mode && a_ext_vld) |=> (hold_val == $past(a_in)));

endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int INVERT      = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_ab,
  input  logic             strobe_ba,
  input  logic             en_ab,
  input  logic             en_ba_n,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  input  logic             a_ext_vld,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  input  logic             b_ext_vld,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);

  localparam logic [WIDTH-1:0] FLIP = (INVERT != 0) ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  logic             rst_core_n;
  xcvr_ctl_t        ctl;
  logic [WIDTH-1:0] reg_ab;
  logic [WIDTH-1:0] reg_ba;
  logic [WIDTH-1:0] hold_val;
  logic [WIDTH-1:0] a_lvl;
  logic [WIDTH-1:0] b_lvl;
  logic             loop_mode;

  always_comb begin
    ctl.en_ab  = en_ab;
    ctl.en_ba  = ~en_ba_n;
    ctl.sel_ab = sel_ab;
    ctl.sel_ba = sel_ba;
  end

  xcvr_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  xcvr_cap_reg #(.WIDTH(WIDTH)) i_cap_ab (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .strobe (strobe_ab),
    .d      (a_lvl),
    .q      (reg_ab)
  );

  xcvr_cap_reg #(.WIDTH(WIDTH)) i_cap_ba (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .strobe (strobe_ba),
    .d      (b_lvl),
    .q      (reg_ba)
  );

  xcvr_route #(.WIDTH(WIDTH), .INVERT(INVERT)) i_route (
    .ctl       (ctl),
    .a_in      (a_in),
    .b_in      (b_in),
    .reg_ab    (reg_ab),
    .reg_ba    (reg_ba),
    .hold_val  (hold_val),
    .a_lvl     (a_lvl),
    .b_lvl     (b_lvl),
    .a_drv     (a_out),
    .b_drv     (b_out),
    .loop_mode (loop_mode)
  );

  xcvr_loop_hold #(.WIDTH(WIDTH), .INVERT(INVERT)) i_loop_hold (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .loop_mode (loop_mode),
    .a_ext_vld (a_ext_vld),
    .b_ext_vld (b_ext_vld),
    .a_in      (a_in),
    .b_in      (b_in),
    .a_lvl     (a_lvl),
    .hold_val  (hold_val)
  );

  assign a_oe = ~en_ba_n;
  assign b_oe = en_ab;

  // R3
  quiet_a_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !a_oe |-> (a_out == '0));

  // R3
  quiet_b_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !b_oe |-> (b_out == '0));

  // R7
  loop_pair_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (a_oe && b_oe && !sel_ab && !sel_ba) |-> (b_out == (a_out ^ FLIP)));

endmodule

// File: tb/test_dual_path_xcvr.sv
module test_dual_path_xcvr;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic strobe_ab, strobe_ba, en_ab, en_ba_n, sel_ab, sel_ba;
  logic [W-1:0] a_in, b_in;
  logic a_ext_vld, b_ext_vld;
  logic [W-1:0] a_out0, b_out0, a_out1, b_out1;
  logic a_oe0, b_oe0, a_oe1, b_oe1;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  logic [W-1:0] m_rab [2];
  logic [W-1:0] m_rba [2];
  logic [W-1:0] m_hold[2];
  logic         m_prev_ab, m_prev_ba;

  always #2 clk = ~clk;

  dual_path_xcvr #(.WIDTH(W), .INVERT(0)) i_dual_path_xcvr (
    .clk(clk), .rst_n(rst_n), .strobe_ab(strobe_ab), .strobe_ba(strobe_ba),
    .en_ab(en_ab), .en_ba_n(en_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .a_ext_vld(a_ext_vld), .a_out(a_out0), .a_oe(a_oe0),
    .b_in(b_in), .b_ext_vld(b_ext_vld), .b_out(b_out0), .b_oe(b_oe0)
  );

  dual_path_xcvr #(.WIDTH(W), .INVERT(1)) i_dual_path_xcvr_inv (
    .clk(clk), .rst_n(rst_n), .strobe_ab(strobe_ab), .strobe_ba(strobe_ba),
    .en_ab(en_ab), .en_ba_n(en_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .a_ext_vld(a_ext_vld), .a_out(a_out1), .a_oe(a_oe1),
    .b_in(b_in), .b_ext_vld(b_ext_vld), .b_out(b_out1), .b_oe(b_oe1)
  );

  // Two-pass bus resolution: settle sides with a fixed source, then the rest.
  task automatic resolve(input int v, output logic [W-1:0] al, output logic [W-1:0] bl);
    logic [W-1:0] f;
    bit a_on, b_on, a_ok, b_ok;
    f    = (v == 1) ? {W{1'b1}} : {W{1'b0}};
    a_on = !en_ba_n;
    b_on = en_ab;
    if (a_on && b_on && !sel_ab && !sel_ba) begin
      al = m_hold[v];
      bl = m_hold[v] ^ f;
    end else begin
      a_ok = 1; b_ok = 1; al = a_in; bl = b_in;
      if (a_on) begin
        if (sel_ba) al = m_rba[v] ^ f; else a_ok = 0;
      end
      if (b_on) begin
        if (sel_ab) bl = m_rab[v] ^ f; else b_ok = 0;
      end
      if (!b_ok) bl = al ^ f;
      if (!a_ok) al = bl ^ f;
    end
  endtask

  function automatic string mode_tag();
    bit a_on, b_on;
    a_on = !en_ba_n;
    b_on = en_ab;
    if (!a_on && !b_on) return "R6";
    if (b_on && !a_on)  return "R4";
    if (a_on && !b_on)  return "R5";
    if (!sel_ab && !sel_ba) return "R7";
    if (sel_ab && sel_ba)   return "R9";
    return "R12";
  endfunction

  task automatic compare(input string tag, input string what, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Sample mid-cycle, then advance one clock and update the model.
  task automatic cycle(input string tag_in);
    logic [W-1:0] al [2];
    logic [W-1:0] bl [2];
    string tag;
    tag = (tag_in == "") ? mode_tag() : tag_in;
    #1;
    for (int v = 0; v < 2; v++) resolve(v, al[v], bl[v]);
    compare("R3", "a_oe", {7'd0, a_oe0}, {7'd0, !en_ba_n});
    compare("R3", "b_oe", {7'd0, b_oe0}, {7'd0, en_ab});
    compare(tag, "a_out true", a_out0, en_ba_n ? '0 : al[0]);
    compare(tag, "b_out true", b_out0, en_ab ? bl[0] : '0);
    compare({tag, "/R10"}, "a_out inv", a_out1, en_ba_n ? '0 : al[1]);
    compare({tag, "/R10"}, "b_out inv", b_out1, en_ab ? bl[1] : '0);
    @(posedge clk);
    for (int v = 0; v < 2; v++) begin
      logic [W-1:0] f;
      f = (v == 1) ? {W{1'b1}} : {W{1'b0}};
      if (strobe_ab && !m_prev_ab) m_rab[v] = al[v];
      if (strobe_ba && !m_prev_ba) m_rba[v] = bl[v];
      if (en_ab && !en_ba_n && !sel_ab && !sel_ba) begin
        if (a_ext_vld)      m_hold[v] = a_in;
        else if (b_ext_vld) m_hold[v] = b_in ^ f;
      end else begin
        m_hold[v] = al[v];
      end
    end
    m_prev_ab = strobe_ab;
    m_prev_ba = strobe_ba;
    @(negedge clk);
  endtask

  task automatic set_ctl(input logic eab, input logic eban, input logic sab, input logic sba);
    en_ab = eab; en_ba_n = eban; sel_ab = sab; sel_ba = sba;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0651);
    rst_n = 1'b0;
    strobe_ab = 0; strobe_ba = 0; a_ext_vld = 0; b_ext_vld = 0;
    a_in = '0; b_in = '0;
    set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
    for (int v = 0; v < 2; v++) begin
      m_rab[v] = '0; m_rba[v] = '0; m_hold[v] = '0;
    end
    m_prev_ab = 0; m_prev_ba = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11: registers cleared, shown through both stored selects
    set_ctl(1'b1, 1'b0, 1'b1, 1'b1);
    a_in = 8'hA5; b_in = 8'h3C;
    cycle("R11");

    // R6: captures with both directions disabled
    set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
    a_in = 8'h5A; b_in = 8'hC3;
    cycle("R6");
    strobe_ab = 1; strobe_ba = 1;
    cycle("R6");
    strobe_ab = 0; strobe_ba = 0;
    set_ctl(1'b1, 1'b0, 1'b1, 1'b1);
    cycle("R9");

    // R1: capture while the register is being shown on B
    set_ctl(1'b1, 1'b1, 1'b1, 1'b0);
    a_in = 8'h81;
    cycle("R1");
    strobe_ab = 1;
    cycle("R1");
    cycle("R1");
    strobe_ab = 0;

    // R2: capture while the register is being shown on A
    set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
    b_in = 8'h7E;
    strobe_ba = 1;
    cycle("R2");
    cycle("R2");
    strobe_ba = 0;

    // R12: capture of a bus level the block drives itself
    set_ctl(1'b1, 1'b0, 1'b0, 1'b1);
    a_in = 8'hFF;
    strobe_ab = 1;
    cycle("R12");
    strobe_ab = 0;
    set_ctl(1'b1, 1'b1, 1'b1, 1'b0);
    cycle("R1");

    // R7 / R8: loop mode hold, then external drivers
    set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
    a_in = 8'h12; b_in = 8'h34;
    cycle("R7");
    a_in = 8'h99; b_in = 8'h66;
    cycle("R7");
    cycle("R7");
    a_ext_vld = 1; a_in = 8'h4D;
    cycle("R8");
    a_ext_vld = 0;
    cycle("R8");
    b_ext_vld = 1; b_in = 8'hB2;
    cycle("R8");
    a_ext_vld = 1; a_in = 8'h0F;
    cycle("R8");
    a_ext_vld = 0; b_ext_vld = 0;
    cycle("R8");

    // Random sweep over all enable/select combinations
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] c;
      c = 4'($urandom());
      set_ctl(c[0], c[1], c[2], c[3]);
      a_in = 8'($urandom());
      b_in = 8'($urandom());
      strobe_ab = ($urandom() % 3) == 0;
      strobe_ba = ($urandom() % 3) == 0;
      a_ext_vld = ($urandom() % 4) == 0;
      b_ext_vld = ($urandom() % 4) == 0;
      cycle("");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule